// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This block sits between a host register interface and an SPI shift engine. It buffers outgoing words in a transmit queue and incoming words in a receive queue, both 16 words deep. It derives eight status flags from the queue levels and from two sticky events, receive overflow and transfer complete. It masks the flags with a per-bit enable and raises one interrupt line.

The host side is stream-shaped. For transmit data, a word moves on a cycle where `host_tx_valid` and `host_tx_ready` are both high. `host_tx_ready` falls while the transmit queue is full, so a word offered then is not taken. For receive data, `host_rx_valid` is high while a word waits, and a read happens on a cycle where `host_rx_ready` is high while `host_rx_valid` is high. The engine side uses plain strobes: `eng_tx_pop` takes the head word shown on `eng_tx_data`, and `eng_rx_push` offers a word to the receive queue. The occupancy of each queue is always visible. Each queue can be emptied through its own soft-reset bit.

Top module: `spi_fifo_irq_unit`

## Requirements
- R1: The transmit queue holds up to 16 words. `host_tx_ready` is low exactly when it is full. A word offered while full is dropped, and both the level and the stored words stay unchanged.
- R2: The engine receives transmit words in host write order. The head word is shown on `eng_tx_data` while `eng_tx_valid` is high. A pop while empty has no effect.
- R3: Words pushed by the engine reach the host in push order. While the receive queue is empty, `host_rx_valid` is low, `host_rx_data` is 0, and asserting `host_rx_ready` changes nothing.
- R4: An engine push into a full receive queue drops the word and sets status bit 6 (overflow). The bit stays set until cleared by writing 1 to it.
- R5: The status bits follow queue occupancy, one cycle after the edge that changes it:
  - bit 0: transmit level is 0
  - bit 1: transmit level is 8 or more
  - bit 2: transmit level is 16
  - bit 3: receive level is 1 or more
  - bit 4: receive level is 8 or more
  - bit 5: receive level is 16
- R6: A `xfer_done` pulse sets status bit 7, which stays set until cleared by writing 1 to it. When a set and a clear fall on the same cycle, the set wins.
- R7: A status write (`stat_w1c_we`) clears only bits 6 and 7, and only where its mask bit is 1. Mask bits 0 to 5, and zero mask bits, have no effect.
- R8: `irq` is high exactly when some status bit and the `irq_enable` bit at the same position are both 1.
- R9: `tx_level` and `rx_level` report the number of stored words, from 0 to 16.
- R10: `fifo_srst` bit 0 empties the transmit queue and bit 1 empties the receive queue, each in one cycle and independently. Neither bit changes status bits 6 or 7.
- R11: After reset, both queues are empty, status reads 8'h01, and `host_tx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_tx_valid | input | 1 | Host offers a transmit word |
| host_tx_ready | output | 1 | Transmit queue can accept a word |
| host_tx_data | input | DATA_W | Transmit word |
| host_rx_valid | output | 1 | A received word is available |
| host_rx_ready | input | 1 | Host takes the received word |
| host_rx_data | output | DATA_W | Head received word, 0 when empty |
| eng_tx_pop | input | 1 | Engine takes the head transmit word |
| eng_tx_valid | output | 1 | Transmit queue not empty |
| eng_tx_data | output | DATA_W | Head transmit word |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | DATA_W | Received word |
| xfer_done | input | 1 | Transfer-complete pulse |
| fifo_srst | input | 2 | Soft reset: bit 0 transmit, bit 1 receive |
| stat_w1c_we | input | 1 | Status clear strobe |
| stat_w1c_mask | input | 8 | Bits to clear (write 1 to clear) |
| irq_enable | input | 8 | Per-flag interrupt enable |
| status | output | 8 | Status flags |
| tx_level | output | clog2(FIFO_DEPTH)+1 | Transmit occupancy |
| rx_level | output | clog2(FIFO_DEPTH)+1 | Receive occupancy |
| irq | output | 1 | Interrupt |

## Verification
A corrupted pointer or level in either queue shows on the next host read or engine pop as a word out of order, or as a level that skips. The level-derived flags bits 0 to 5 then disagree with the count of words written minus words read, in the very next cycle. A sticky bit that drops or sets on its own reaches `status` and, when its enable bit is set, `irq`, one cycle after the offending edge. The bench therefore checks levels, flags and data words immediately after each stimulus cycle.

// File: rtl/spi_fifo_irq_pkg.sv
package spi_fifo_irq_pkg;
  localparam int NUM_FLAGS  = 8;
  localparam int F_TX_EMPTY = 0;
  localparam int F_TX_HALF  = 1;
  localparam int F_TX_FULL  = 2;
  localparam int F_RX_READY = 3;
  localparam int F_RX_HALF  = 4;
  localparam int F_RX_FULL  = 5;
  localparam int F_RX_OVF   = 6;
  localparam int F_XFER_END = 7;
  localparam int SRST_TX    = 0;
  localparam int SRST_RX    = 1;
endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     wr_en,
  input  logic [WIDTH-1:0]         wr_data,
  input  logic                     rd_en,
  output logic [WIDTH-1:0]         rd_data,
  output logic [$clog2(DEPTH):0]   count,
  output logic                     full,
  output logic                     empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic             push, pop;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign push  = wr_en && !full;
  assign pop   = rd_en && !empty;
  assign rd_data = mem[rptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= bump(wptr);
      if (pop)  rptr <= bump(rptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/spi_status_flags.sv
module spi_status_flags
  import spi_fifo_irq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(DEPTH):0]  tx_count,
  input  logic [$clog2(DEPTH):0]  rx_count,
  input  logic                    rx_push,
  input  logic                    xfer_done,
  input  logic                    w1c_we,
  input  logic [NUM_FLAGS-1:0]    w1c_mask,
  output logic [NUM_FLAGS-1:0]    flags
);
  localparam int CW   = $clog2(DEPTH) + 1;
  localparam int HALF = DEPTH / 2;

  logic ovf_q, done_q;
  logic rx_is_full;

  assign rx_is_full = (rx_count == CW'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (rx_push && rx_is_full)             ovf_q <= 1'b1;
      else if (w1c_we && w1c_mask[F_RX_OVF]) ovf_q <= 1'b0;
      if (xfer_done)                           done_q <= 1'b1;
      else if (w1c_we && w1c_mask[F_XFER_END]) done_q <= 1'b0;
    end
  end

  always_comb begin
    flags             = '0;
    flags[F_TX_EMPTY] = (tx_count == '0);
    flags[F_TX_HALF]  = (tx_count >= CW'(HALF));
    flags[F_TX_FULL]  = (tx_count == CW'(DEPTH));
    flags[F_RX_READY] = (rx_count != '0);
    flags[F_RX_HALF]  = (rx_count >= CW'(HALF));
    flags[F_RX_FULL]  = rx_is_full;
    flags[F_RX_OVF]   = ovf_q;
    flags[F_XFER_END] = done_q;
  end
endmodule

// File: rtl/spi_irq_mask.sv
module spi_irq_mask
  import spi_fifo_irq_pkg::*;
(
  input  logic [NUM_FLAGS-1:0] flags,
  input  logic [NUM_FLAGS-1:0] enable,
  output logic                 irq
);
  logic [NUM_FLAGS-1:0] hit;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_bit
    assign hit[g] = flags[g] & enable[g];
  end

  assign irq = |hit;
endmodule

// File: rtl/spi_fifo_irq_unit.sv
module spi_fifo_irq_unit
  import spi_fifo_irq_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         host_tx_valid,
  output logic                         host_tx_ready,
  input  logic [DATA_W-1:0]            host_tx_data,
  output logic                         host_rx_valid,
  input  logic                         host_rx_ready,
  output logic [DATA_W-1:0]            host_rx_data,
  input  logic                         eng_tx_pop,
  output logic                         eng_tx_valid,
  output logic [DATA_W-1:0]            eng_tx_data,
  input  logic                         eng_rx_push,
  input  logic [DATA_W-1:0]            eng_rx_data,
  input  logic                         xfer_done,
  input  logic [1:0]                   fifo_srst,
  input  logic                         stat_w1c_we,
  input  logic [7:0]                   stat_w1c_mask,
  input  logic [7:0]                   irq_enable,
  output logic [7:0]                   status,
  output logic [$clog2(FIFO_DEPTH):0]  tx_level,
  output logic [$clog2(FIFO_DEPTH):0]  rx_level,
  output logic                         irq
);
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic [DATA_W-1:0] rx_head;

  spi_word_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .clr(fifo_srst[SRST_TX]),
    .wr_en(host_tx_valid), .wr_data(host_tx_data),
    .rd_en(eng_tx_pop), .rd_data(eng_tx_data),
    .count(tx_level), .full(tx_full), .empty(tx_empty)
  );

  spi_word_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .clr(fifo_srst[SRST_RX]),
    .wr_en(eng_rx_push), .wr_data(eng_rx_data),
    .rd_en(host_rx_ready), .rd_data(rx_head),
    .count(rx_level), .full(rx_full), .empty(rx_empty)
  );

  assign host_tx_ready = !tx_full;
  assign eng_tx_valid  = !tx_empty;
  assign host_rx_valid = !rx_empty;
  assign host_rx_data  = rx_empty ? '0 : rx_head;

  spi_status_flags #(.DEPTH(FIFO_DEPTH)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .tx_count(tx_level), .rx_count(rx_level),
    .rx_push(eng_rx_push), .xfer_done(xfer_done),
    .w1c_we(stat_w1c_we), .w1c_mask(stat_w1c_mask),
    .flags(status)
  );

  spi_irq_mask u_irq (
    .flags(status), .enable(irq_enable), .irq(irq)
  );
endmodule

// File: rtl/spi_fifo_irq_unit_chk.sv
module spi_fifo_irq_unit_chk #(
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 16
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        host_tx_valid,
  input logic                        host_tx_ready,
  input logic                        host_rx_valid,
  input logic                        host_rx_ready,
  input logic [DATA_W-1:0]           host_rx_data,
  input logic                        eng_tx_pop,
  input logic                        eng_rx_push,
  input logic                        xfer_done,
  input logic [1:0]                  fifo_srst,
  input logic                        stat_w1c_we,
  input logic [7:0]                  stat_w1c_mask,
  input logic [7:0]                  irq_enable,
  input logic [7:0]                  status,
  input logic [$clog2(FIFO_DEPTH):0] tx_level,
  input logic [$clog2(FIFO_DEPTH):0] rx_level,
  input logic                        irq
);
  localparam int CW = $clog2(FIFO_DEPTH) + 1;

  assert_level_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= CW'(FIFO_DEPTH)) && (rx_level <= CW'(FIFO_DEPTH)));

  assert_full_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == CW'(FIFO_DEPTH)) |-> !host_tx_ready);

  assert_full_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_tx_ready && !eng_tx_pop && !fifo_srst[0]) |=> $stable(tx_level));

  assert_empty_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rx_valid |-> (host_rx_data == '0));

  assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (status[6] && !(stat_w1c_we && stat_w1c_mask[6])) |=> status[6]);

  assert_done_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> status[7]);

  assert_done_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_w1c_we && stat_w1c_mask[7] && !xfer_done) |=> !status[7]);

  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & irq_enable) == 8'h00) |-> !irq);

  assert_srst_tx_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_srst[0] |=> (tx_level == '0));

  assert_srst_rx_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_srst[1] |=> (rx_level == '0));

  assert_level_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_srst[1] |=> ((rx_level == $past(rx_level)) ||
                       (rx_level == $past(rx_level) + 1'b1) ||
                       (rx_level == $past(rx_level) - 1'b1)));
endmodule

bind spi_fifo_irq_unit spi_fifo_irq_unit_chk #(
  .DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH)
) chk_i (.*);

// File: tb/spi_fifo_irq_unit_tb_top.sv
module spi_fifo_irq_unit_tb_top;
  localparam int DW = 32;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_tx_valid = 0, host_rx_ready = 0, eng_tx_pop = 0, eng_rx_push = 0;
  logic xfer_done = 0, stat_w1c_we = 0;
  logic [DW-1:0] host_tx_data = '0, eng_rx_data = '0;
  logic [1:0] fifo_srst = '0;
  logic [7:0] stat_w1c_mask = '0, irq_enable = '0;
  logic host_tx_ready, host_rx_valid, eng_tx_valid, irq;
  logic [DW-1:0] host_rx_data, eng_tx_data;
  logic [7:0] status;
  logic [4:0] tx_level, rx_level;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  spi_fifo_irq_unit #(.DATA_W(DW), .FIFO_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_tx_valid(host_tx_valid), .host_tx_ready(host_tx_ready), .host_tx_data(host_tx_data),
    .host_rx_valid(host_rx_valid), .host_rx_ready(host_rx_ready), .host_rx_data(host_rx_data),
    .eng_tx_pop(eng_tx_pop), .eng_tx_valid(eng_tx_valid), .eng_tx_data(eng_tx_data),
    .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
    .xfer_done(xfer_done), .fifo_srst(fifo_srst),
    .stat_w1c_we(stat_w1c_we), .stat_w1c_mask(stat_w1c_mask),
    .irq_enable(irq_enable), .status(status),
    .tx_level(tx_level), .rx_level(rx_level), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drives happen at the falling edge; one rising edge passes, strobes drop.
  task automatic tick();
    @(negedge clk);
    host_tx_valid = 0; host_rx_ready = 0; eng_tx_pop = 0; eng_rx_push = 0;
    xfer_done = 0; stat_w1c_we = 0; stat_w1c_mask = '0; fifo_srst = '0;
  endtask

  task automatic host_write(input logic [31:0] d);
    host_tx_valid = 1; host_tx_data = d; tick();
  endtask

  task automatic eng_push(input logic [31:0] d);
    eng_rx_push = 1; eng_rx_data = d; tick();
  endtask

  task automatic clear_bits(input logic [7:0] m);
    stat_w1c_we = 1; stat_w1c_mask = m; tick();
  endtask

  task automatic test_reset();
    check("R11 status", {24'h0, status}, 32'h01);
    check("R11 tx_level", {27'h0, tx_level}, 0);
    check("R11 rx_level", {27'h0, rx_level}, 0);
    check("R11 tx_ready", {31'h0, host_tx_ready}, 1);
    check("R3 empty rx_valid", {31'h0, host_rx_valid}, 0);
    check("R8 irq off", {31'h0, irq}, 0);
  endtask

  task automatic test_tx_path();
    for (int i = 0; i < DEPTH; i++) begin
      host_write(32'h100 + i * 3);
      check("R9 tx level", {27'h0, tx_level}, i + 1);
      if (i == 7) check("R5 tx half", {31'h0, status[1]}, 1);
      if (i == 6) check("R5 tx below half", {31'h0, status[1]}, 0);
    end
    check("R5 tx full", {29'h0, status[2:0]}, 3'b110);
    check("R1 ready low", {31'h0, host_tx_ready}, 0);
    host_write(32'hDEAD);
    check("R1 full write dropped", {27'h0, tx_level}, DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      check("R2 head order", eng_tx_data, 32'h100 + i * 3);
      eng_tx_pop = 1; tick();
    end
    check("R2 empty valid", {31'h0, eng_tx_valid}, 0);
    check("R5 tx empty", {29'h0, status[2:0]}, 3'b001);
    eng_tx_pop = 1; tick();
    check("R2 pop empty ignored", {27'h0, tx_level}, 0);
    host_write(32'hA5A5);
    check("R2 next word", eng_tx_data, 32'hA5A5);
    eng_tx_pop = 1; tick();
  endtask

  task automatic test_rx_path();
    host_rx_ready = 1; tick();
    check("R3 empty read level", {27'h0, rx_level}, 0);
    check("R3 empty read data", host_rx_data, 0);
    for (int i = 0; i < 3; i++) eng_push(32'hC000 + i);
    check("R5 rx ready", {29'h0, status[5:3]}, 3'b001);
    for (int i = 0; i < 3; i++) begin
      check("R3 rx order", host_rx_data, 32'hC000 + i);
      host_rx_ready = 1; tick();
    end
    check("R3 drained", {31'h0, host_rx_valid}, 0);
  endtask

  task automatic test_overflow();
    for (int i = 0; i < DEPTH; i++) eng_push(32'hE00 + i);
    check("R5 rx full", {29'h0, status[5:3]}, 3'b111);
    check("R4 no ovf yet", {31'h0, status[6]}, 0);
    eng_push(32'hBAD);
    check("R4 ovf set", {31'h0, status[6]}, 1);
    check("R4 level held", {27'h0, rx_level}, DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      check("R4 no dropped word", host_rx_data, 32'hE00 + i);
      host_rx_ready = 1; tick();
    end
    check("R4 ovf sticky", {31'h0, status[6]}, 1);
    clear_bits(8'h3F);
    check("R7 low bits no effect", {24'h0, status}, 32'h41);
    clear_bits(8'h40);
    check("R4 ovf cleared", {31'h0, status[6]}, 0);
  endtask

  task automatic test_done();
    xfer_done = 1; tick();
    check("R6 done set", {31'h0, status[7]}, 1);
    tick(); tick();
    check("R6 done sticky", {31'h0, status[7]}, 1);
    clear_bits(8'h00);
    check("R7 zero mask", {31'h0, status[7]}, 1);
    clear_bits(8'h80);
    check("R6 done cleared", {31'h0, status[7]}, 0);
    xfer_done = 1; stat_w1c_we = 1; stat_w1c_mask = 8'h80; tick();
    check("R6 set wins", {31'h0, status[7]}, 1);
    clear_bits(8'h80);
  endtask

  task automatic test_irq();
    irq_enable = 8'h01; #1;
    check("R8 tx empty irq", {31'h0, irq}, 1);
    irq_enable = 8'hFE; #1;
    check("R8 masked", {31'h0, irq}, 0);
    irq_enable = 8'h80; xfer_done = 1; tick();
    check("R8 done irq", {31'h0, irq}, 1);
    clear_bits(8'h80);
    check("R8 done irq off", {31'h0, irq}, 0);
    irq_enable = 8'h08; eng_push(32'h1); 
    check("R8 rx irq", {31'h0, irq}, 1);
    host_rx_ready = 1; tick();
    check("R8 rx irq off", {31'h0, irq}, 0);
    irq_enable = 8'h00;
  endtask

  task automatic test_srst();
    for (int i = 0; i < 5; i++) host_write(i);
    for (int i = 0; i < 4; i++) eng_push(i);
    xfer_done = 1; tick();
    fifo_srst = 2'b01; tick();
    check("R10 tx emptied", {27'h0, tx_level}, 0);
    check("R10 rx kept", {27'h0, rx_level}, 4);
    check("R10 done kept", {31'h0, status[7]}, 1);
    fifo_srst = 2'b10; tick();
    check("R10 rx emptied", {27'h0, rx_level}, 0);
    check("R10 status", {24'h0, status}, 32'h81);
    clear_bits(8'h80);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    test_reset();
    test_tx_path();
    test_rx_path();
    test_overflow();
    test_done();
    test_irq();
    test_srst();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule